// File: doc/BRIEF.md
# Conversion Handshake and Serial Result Readout

This block sequences one conversion per host transaction and returns the result over a single serial data line. The host pulls its active-low chip select low. The block then latches the level of the channel-select input and issues a one-cycle start pulse, with the chosen channel, to the conversion engine. The engine returns a parallel result together with a one-cycle done pulse. The engine itself is outside this block.

The serial data line carries the handshake as well as the data. The line leaves high impedance and drives low while the conversion is in progress. It switches high as soon as the result is captured. Each falling edge of the host serial clock then places the next result bit on the line, most significant bit first. The word is a sign bit followed by a 15-bit magnitude. The line floats again when the host raises chip select. A rise before all bits are sent aborts the transaction at once.

The host chip select and serial clock are brought into the local clock domain by a chain of synchronizer flops. All edges are detected on the synchronized levels. The tri-state pad is represented by a data output and an output enable.

Top module: `serialConvReadout`

## Requirements
- R1: While reset is held, and after its release, the output enable `sdatOe` is low and `convStart` is low.
- R2: A falling edge of `csN` while idle produces a single-cycle `convStart` pulse. In that same cycle `sdatOe` goes high and `sdatOut` is 0, and the line stays 0 until the result is captured.
- R3: `convChan` takes the `chanSel` level present at the chip-select falling edge, where 0 means channel 1 and 1 means channel 2. It holds that value for the whole transaction, whatever `chanSel` does afterwards.
- R4: A `resultValid` pulse while the line shows busy captures `resultData`, and `sdatOut` reads 1 (ready) from the next cycle onwards.
- R5: After the ready indication, the first falling edge of `sclk` puts bit 15 (the sign) on `sdatOut`. Each later falling edge puts the next lower bit there, until bit 0 has been presented after 16 edges.
- R6: Once bit 0 has been presented, further `sclk` falling edges are ignored and `sdatOut` keeps showing bit 0 while `csN` stays low.
- R7: A rising edge of `csN` in any active state drives `sdatOe` low on the next cycle. If the rise comes before all 16 bits have gone out, the remaining bits are discarded, and the next transaction starts afresh with its own busy, ready and MSB sequence.
- R8: `resultValid` has no effect outside the busy phase. It neither enables the line while idle nor alters the bits being shifted out.
- R9: While the line is enabled, `sdatOut` changes only one cycle after a capture or after an accepted `sclk` falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Host chip select, active low, asynchronous to clk |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| chanSel | input | 1 | Channel choice for the next conversion (0 = channel 1, 1 = channel 2) |
| resultData | input | 16 | Conversion result, sign in bit 15 and magnitude below |
| resultValid | input | 1 | One-cycle pulse marking resultData valid |
| convStart | output | 1 | One-cycle request to start a conversion |
| convChan | output | 1 | Channel latched for the current conversion |
| sdatOut | output | 1 | Serial line value: busy 0, ready 1, then result bits |
| sdatOe | output | 1 | Serial line drive enable; low means high impedance |

## Verification
The full readout is tried with zero, all-ones, sign-only, magnitude-only and alternating words, and with a walking one over all 16 positions. The walking one separates a wrong bit order or an off-by-one bit count from a stuck line. Both channel values are used, with `chanSel` flipped during every transaction, which shows whether the channel is latched or merely passed through. Chip-select rises are placed during busy, in mid-word, and after extra clock edges. Stray done pulses are applied while idle and in mid-shift. Together these separate the abort path, the hold of bit 0 and the masking of the done pulse from normal completion.

// File: rtl/convReadoutPkg.sv
package convReadoutPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_SHIFT = 2'd2
  } ctrlState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;    // open a transaction
    logic capture;  // load the result word
    logic shift;    // present next bit
    logic drop;     // close or abort the transaction
  } ctrlStrobes_t;

endpackage

// File: rtl/convInSync.sv
module convInSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~level;
  assign rise  = ~prev & level;

endmodule

// File: rtl/convReadCtrl.sv
module convReadCtrl
  import convReadoutPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csFall,
  input  logic         csRise,
  input  logic         sclkFall,
  input  logic         resultValid,
  input  logic         allSent,
  output ctrlStrobes_t strobes,
  output logic         lineOe
);

  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (csFall) begin
          strobes.start = 1'b1;
          stateNext     = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (csRise) begin
          strobes.drop = 1'b1;
          stateNext    = ST_IDLE;
        end else if (resultValid) begin
          strobes.capture = 1'b1;
          stateNext       = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (csRise) begin
          strobes.drop = 1'b1;
          stateNext    = ST_IDLE;
        end else if (sclkFall && !allSent) begin
          strobes.shift = 1'b1;
        end
      end
      default: begin
        strobes.drop = 1'b1;
        stateNext    = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign lineOe = (state != ST_IDLE);

endmodule

// File: rtl/convReadPath.sv
module convReadPath
  import convReadoutPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              chanSel,
  input  logic [DATA_W-1:0] resultData,
  output logic              convStart,
  output logic              convChan,
  output logic              lineBit,
  output logic              allSent
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      convChan  <= 1'b0;
      lineBit   <= 1'b0;
      shReg     <= '0;
      bitCnt    <= '0;
    end else begin
      convStart <= strobes.start;
      if (strobes.start) begin
        convChan <= chanSel;
        lineBit  <= 1'b0;
        bitCnt   <= '0;
      end
      if (strobes.capture) begin
        shReg   <= resultData;
        lineBit <= 1'b1;
      end
      if (strobes.shift) begin
        lineBit <= shReg[DATA_W-1];
        shReg   <= {shReg[DATA_W-2:0], 1'b0};
        bitCnt  <= bitCnt + 1'b1;
      end
      if (strobes.drop) begin
        lineBit <= 1'b0;
        bitCnt  <= '0;
      end
    end
  end

  assign allSent = (bitCnt == CNT_W'(DATA_W));

endmodule

// File: rtl/serialConvReadout.sv
module serialConvReadout
  import convReadoutPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              chanSel,
  input  logic [DATA_W-1:0] resultData,
  input  logic              resultValid,
  output logic              convStart,
  output logic              convChan,
  output logic              sdatOut,
  output logic              sdatOe
);

  logic         csLevel, csFall, csRise;
  logic         sclkLevel, sclkFall, sclkRise;
  logic         allSent;
  ctrlStrobes_t strobes;

  convInSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_csSync (
    .clk(clk), .rstN(rstN), .din(csN),
    .level(csLevel), .fall(csFall), .rise(csRise)
  );

  convInSync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sclkSync (
    .clk(clk), .rstN(rstN), .din(sclk),
    .level(sclkLevel), .fall(sclkFall), .rise(sclkRise)
  );

  convReadCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .csFall(csFall), .csRise(csRise), .sclkFall(sclkFall),
    .resultValid(resultValid), .allSent(allSent),
    .strobes(strobes), .lineOe(sdatOe)
  );

  convReadPath #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .chanSel(chanSel), .resultData(resultData),
    .convStart(convStart), .convChan(convChan),
    .lineBit(sdatOut), .allSent(allSent)
  );

endmodule

// File: rtl/serialConvReadoutChk.sv
module serialConvReadoutChk
  import convReadoutPkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         csFall,
  input logic         csRise,
  input logic         resultValid,
  input logic         allSent,
  input ctrlStrobes_t strobes,
  input logic         convStart,
  input logic         convChan,
  input logic         sdatOut,
  input logic         sdatOe
);

  // R1 / R2: the line only becomes enabled together with the start pulse, driving busy low
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdatOe) |-> (convStart && !sdatOut));

  // R3: the latched channel does not move during a transaction
  a_r3_chan_held: assert property (@(posedge clk) disable iff (!rstN)
    (sdatOe && $past(sdatOe)) |-> $stable(convChan));

  // R6: after the last bit the line holds its value
  a_r6_hold_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (sdatOe && $past(sdatOe) && $past(allSent)) |-> $stable(sdatOut));

  // R7: a chip-select rise floats the line next cycle
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !sdatOe);

  // R8: a done pulse while idle does not enable the line
  a_r8_idle_valid: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !sdatOe && !csFall) |=> !sdatOe);

  // R9: line changes only after capture or an accepted shift
  a_r9_change_cause: assert property (@(posedge clk) disable iff (!rstN)
    (sdatOe && $past(sdatOe) && (sdatOut != $past(sdatOut)))
      |-> ($past(strobes.capture) || $past(strobes.shift)));

endmodule

bind serialConvReadout serialConvReadoutChk i_chk (
  .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
  .resultValid(resultValid), .allSent(allSent), .strobes(strobes),
  .convStart(convStart), .convChan(convChan),
  .sdatOut(sdatOut), .sdatOe(sdatOe)
);

// File: tb/test_serialConvReadout.sv
module test_serialConvReadout;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int SETTLE = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          sclk = 1'b1;
  logic          chanSel = 1'b0;
  logic [DW-1:0] resultData = '0;
  logic          resultValid = 1'b0;
  logic          convStart, convChan, sdatOut, sdatOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialConvReadout i_serialConvReadout (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .chanSel(chanSel),
    .resultData(resultData), .resultValid(resultValid),
    .convStart(convStart), .convChan(convChan),
    .sdatOut(sdatOut), .sdatOe(sdatOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseValid(input logic [DW-1:0] d);
    resultData  = d;
    resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic openCycle(input logic ch, output bit seen);
    seen = 0;
    chanSel = ch;
    waitNeg(2);
    csN = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (convStart) seen = 1;
    end
    chk("R2 start pulse", seen, 1);
    chk("R2 busy enable", sdatOe, 1);
    chk("R2 busy low", sdatOut, 0);
    chk("R3 channel latched", convChan, ch);
    @(negedge clk);
    chk("R2 pulse single cycle", convStart, 0);
    chanSel = ~ch;
  endtask

  // abortAt < DW closes the cycle after that many bits
  task automatic runCycle(input logic [DW-1:0] d, input logic ch, input int abortAt,
                          input bit strayValid);
    bit seen;
    openCycle(ch, seen);
    waitNeg(3);
    chk("R2 still busy", {sdatOe, sdatOut}, 2'b10);
    chk("R3 channel held", convChan, ch);
    pulseValid(d);
    @(negedge clk);
    chk("R4 ready high", {sdatOe, sdatOut}, 2'b11);
    for (int i = 0; i < DW; i++) begin
      if (i == abortAt) break;
      if (strayValid && i == DW/2) pulseValid(~d);
      sclk = 1'b0;
      waitNeg(SETTLE);
      chk("R5 bit value", sdatOut, d[DW-1-i]);
      chk("R3 channel held", convChan, ch);
      sclk = 1'b1;
      waitNeg(SETTLE);
    end
    if (abortAt >= DW) begin
      for (int k = 0; k < 2; k++) begin
        sclk = 1'b0; waitNeg(SETTLE);
        sclk = 1'b1; waitNeg(SETTLE);
        chk("R6 holds bit 0", {sdatOe, sdatOut}, {1'b1, d[0]});
      end
    end
    csN = 1'b1;
    waitNeg(SETTLE);
    chk("R7 released", sdatOe, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit seen;
    waitNeg(3);
    chk("R1 reset oe", sdatOe, 0);
    chk("R1 reset start", convStart, 0);
    rstN = 1'b1;
    waitNeg(4);
    chk("R1 after reset oe", sdatOe, 0);
    chk("R1 after reset start", convStart, 0);

    // R8: done pulse while idle
    pulseValid(16'h1234);
    waitNeg(3);
    chk("R8 idle valid ignored", sdatOe, 0);

    // R5: fixed patterns on both channels
    runCycle(16'h0000, 1'b0, DW, 0);
    runCycle(16'hFFFF, 1'b1, DW, 0);
    runCycle(16'h8000, 1'b0, DW, 0);
    runCycle(16'h7FFF, 1'b1, DW, 0);
    runCycle(16'hA5A5, 1'b0, DW, 1);   // R8 stray valid mid-shift
    runCycle(16'h5A5A, 1'b1, DW, 1);
    // walking one
    for (int p = 0; p < DW; p++) begin
      runCycle(DW'(1) << p, p[0], DW, 0);
    end

    // R7: abort mid-word, then fresh cycle
    runCycle(16'hC3C3, 1'b1, 5, 0);
    runCycle(16'h3C3C, 1'b0, DW, 0);
    runCycle(16'h9999, 1'b0, 0, 0);

    // R7 / R8: abort during busy, late done pulse ignored
    openCycle(1'b1, seen);
    csN = 1'b1;
    waitNeg(SETTLE);
    chk("R7 abort in busy", sdatOe, 0);
    pulseValid(16'hBEEF);
    waitNeg(3);
    chk("R8 late valid ignored", sdatOe, 0);
    runCycle(16'hBEEF, 1'b1, DW, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule